// File: doc/BRIEF.md
# Interrupt Mask and Serial-Bit Controller

This block keeps the mask state for three maskable interrupt inputs, a global interrupt-enable flag, a latch that catches rising edges on the top-priority input, and a one-bit serial output register. A processor core loads it from an 8-bit accumulator value on a write strobe. It reads back an 8-bit status word on a read strobe. The word shows the serial input pin, which requests are pending, the enable flag and the masks.

The block also drives a prioritized request to the core, with a one-hot code that names the winning input. The core clears the enable flag when it acknowledges. Separate strobes set and clear the flag.

The three inputs are named by rank: `irq_hi` is edge-latched, while `irq_mid` and `irq_lo` are level-sensitive.

Top module: `intmask_ctrl`

## Requirements
- R1: After reset, all three mask bits are 1, the enable flag is 0, the edge latch is 0 and `ser_out` is 0. With all pins low, the status word reads 0x07.
- R2: While `rd_stb` is high, `rd_data` has the following layout:
  - bit 7 = `ser_in`
  - bit 6 = edge latch of `irq_hi`
  - bit 5 = `irq_mid` pin
  - bit 4 = `irq_lo` pin
  - bit 3 = enable flag
  - bits 2..0 = masks for hi, mid and lo (1 = masked)

  While `rd_stb` is low, `rd_data` is 0x00. A latched hi request with enable set and only lo masked reads 0x49.
- R3: On `wr_stb`, `wr_data[2:0]` loads the masks (bit 2 hi, bit 1 mid, bit 0 lo) only if `wr_data[3]` is 1. Otherwise the masks hold.
- R4: On `wr_stb`, `wr_data[7]` loads `ser_out` only if `wr_data[6]` is 1. Otherwise `ser_out` holds. `wr_data[5]` has no effect.
- R5: On `wr_stb`, `wr_data[4]` = 1 clears the edge latch, whatever the value of `wr_data[3]`.
- R6: A rising edge on `irq_hi` sets the edge latch. The latch stays set after the pin falls. `irq_mid` and `irq_lo` are reported straight from the pins.
- R7: `irq` is 1 only when the enable flag is 1 and at least one pending request is unmasked.
- R8: The winner is chosen in the order hi, then mid, then lo. `irq_code` is one-hot (100 = hi, 010 = mid, 001 = lo) and is 000 when `irq` is 0.
- R9: `ack` clears the enable flag. It clears the edge latch only when hi is the current winner.
- R10: `ei_stb` sets the enable flag and `di_stb` clears it. When `ei_stb` arrives in the same cycle as `di_stb` or `ack`, the flag is cleared.
- R11: A clear of the edge latch (write bit 4, or an acknowledge of hi) takes priority over a rising edge on `irq_hi` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | Write strobe for the control word |
| wr_data | input | 8 | Control word |
| rd_stb | input | 1 | Read strobe for the status word |
| rd_data | output | 8 | Status word |
| ser_in | input | 1 | Serial input pin |
| ser_out | output | 1 | Serial output latch |
| irq_hi | input | 1 | Top-priority request, edge-latched |
| irq_mid | input | 1 | Middle-priority request, level |
| irq_lo | input | 1 | Lowest-priority request, level |
| ei_stb | input | 1 | Set the enable flag |
| di_stb | input | 1 | Clear the enable flag |
| ack | input | 1 | Interrupt acknowledge |
| irq | output | 1 | Request to the core |
| irq_code | output | 3 | One-hot winner code |

## Verification
The assertions assume that every strobe is synchronous to `clk` and lasts a single cycle. They also assume that the inputs do not change within a cycle.

The bench drives every input just after a falling edge and holds it across the next rising edge. It releases each strobe after one cycle and samples at the following falling edge.

The bench keeps `irq_hi` low during and just after reset. An edge seen by the latch therefore always comes from the stimulus.

// File: rtl/intmask_ctrl.sv
module intmask_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stb,
  input  logic [7:0] wr_data,
  input  logic       rd_stb,
  output logic [7:0] rd_data,
  input  logic       ser_in,
  output logic       ser_out,
  input  logic       irq_hi,
  input  logic       irq_mid,
  input  logic       irq_lo,
  input  logic       ei_stb,
  input  logic       di_stb,
  input  logic       ack,
  output logic       irq,
  output logic [2:0] irq_code
);
  logic [2:0] mask_q;
  logic       en_q, lat_q, hi_d, sod_q;

  wire [2:0] pend = {lat_q, irq_mid, irq_lo};
  wire [2:0] live = pend & ~mask_q;

  assign irq = en_q & (|live);

  always_comb begin
    irq_code = 3'b000;
    if (en_q) begin
      if (live[2])      irq_code = 3'b100;
      else if (live[1]) irq_code = 3'b010;
      else if (live[0]) irq_code = 3'b001;
    end
  end

  wire lat_clr = (wr_stb & wr_data[4]) | (ack & irq_code[2]);
  wire hi_rise = irq_hi & ~hi_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= 3'b111;
      en_q   <= 1'b0;
      lat_q  <= 1'b0;
      hi_d   <= 1'b0;
      sod_q  <= 1'b0;
    end else begin
      hi_d <= irq_hi;
      if (lat_clr)      lat_q <= 1'b0;
      else if (hi_rise) lat_q <= 1'b1;
      if (ack | di_stb) en_q <= 1'b0;
      else if (ei_stb)  en_q <= 1'b1;
      if (wr_stb && wr_data[3]) mask_q <= wr_data[2:0];
      if (wr_stb && wr_data[6]) sod_q  <= wr_data[7];
    end
  end

  assign ser_out = sod_q;
  assign rd_data = rd_stb ? {ser_in, pend, en_q, mask_q} : 8'h00;
endmodule

// File: rtl/intmask_ctrl_chk.sv
module intmask_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_stb,
  input logic [7:0] wr_data,
  input logic       ack,
  input logic       irq,
  input logic [2:0] irq_code,
  input logic [2:0] mask_q,
  input logic       en_q,
  input logic       lat_q,
  input logic       sod_q
);
  p_code_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_code) && (irq == (irq_code != 3'b000)));
  p_irq_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> en_q);
  p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !wr_data[3]) |=> $stable(mask_q));
  p_sod_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !wr_data[6]) |=> $stable(sod_q));
  p_wr_clears_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_data[4]) |=> !lat_q);
  p_ack_drops_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !en_q);
  p_hi_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_code[1] || irq_code[0]) |-> !(lat_q && !mask_q[2]));
endmodule

bind intmask_ctrl intmask_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data), .ack(ack),
  .irq(irq), .irq_code(irq_code), .mask_q(mask_q), .en_q(en_q),
  .lat_q(lat_q), .sod_q(sod_q)
);

// File: tb/tb_intmask_ctrl.sv
`timescale 1ns/1ps
module tb_intmask_ctrl;
  logic clk = 0, rst_n = 0;
  logic wr_stb = 0, rd_stb = 1, ser_in = 0;
  logic irq_hi = 0, irq_mid = 0, irq_lo = 0, ei_stb = 0, di_stb = 0, ack = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic ser_out, irq;
  logic [2:0] irq_code;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  intmask_ctrl dut (.*);

  // {write word, expected status, expected ser_out}, starting from reset state
  localparam logic [16:0] VEC [8] = '{
    {8'h08, 8'h00, 1'b0}, {8'h05, 8'h00, 1'b0}, {8'h0D, 8'h05, 1'b0},
    {8'hC2, 8'h05, 1'b1}, {8'h0A, 8'h02, 1'b1}, {8'h40, 8'h02, 1'b0},
    {8'hBF, 8'h07, 1'b0}, {8'hE8, 8'h00, 1'b1}};

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic wr(logic [7:0] d);
    wr_stb = 1; wr_data = d; tick(); wr_stb = 0; wr_data = 0;
  endtask

  task automatic pulse_hi();
    irq_hi = 1; tick(); irq_hi = 0;
  endtask

  task automatic do_ei(); ei_stb = 1; tick(); ei_stb = 0; endtask
  task automatic do_ack(); ack = 1; tick(); ack = 0; endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tick(); tick(); rst_n = 1; tick();
    chk("R1 status after reset", rd_data, 8'h07);
    chk("R1 ser_out after reset", {7'b0, ser_out}, 8'h00);
    chk("R7 irq after reset", {7'b0, irq}, 8'h00);
    rd_stb = 0; #1;
    chk("R2 rd_data idle", rd_data, 8'h00);
    rd_stb = 1;

    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][16:9]);
      chk($sformatf("R3 vec %0d status", i), rd_data, VEC[i][8:1]);
      chk($sformatf("R4 vec %0d ser_out", i), {7'b0, ser_out}, {7'b0, VEC[i][0]});
    end

    pulse_hi();
    chk("R6 latch holds after pin falls", rd_data, 8'h40);
    chk("R7 no irq while disabled", {7'b0, irq}, 8'h00);
    do_ei();
    chk("R10 enable set", rd_data, 8'h48);
    chk("R8 hi wins", {5'b0, irq_code}, 8'h04);
    wr(8'h09);
    chk("R2 status 0x49", rd_data, 8'h49);
    chk("R4 ser_out kept", {7'b0, ser_out}, 8'h01);
    irq_mid = 1; irq_lo = 1; #1;
    chk("R6 level pins", rd_data, 8'h79);
    chk("R8 hi over mid", {5'b0, irq_code}, 8'h04);
    wr(8'h10);
    chk("R5 clear without mask write", rd_data, 8'h39);
    chk("R8 mid wins", {5'b0, irq_code}, 8'h02);
    wr(8'h0E);
    chk("R7 masked mid skipped", rd_data, 8'h3E);
    chk("R8 lo wins", {5'b0, irq_code}, 8'h01);
    do_ack();
    chk("R9 ack clears enable", rd_data, 8'h36);
    chk("R7 irq off after ack", {7'b0, irq}, 8'h00);

    wr(8'h0C); pulse_hi(); do_ei();
    chk("R7 hi masked", rd_data, 8'h7C);
    chk("R8 mid wins over masked hi", {5'b0, irq_code}, 8'h02);
    do_ack();
    chk("R9 latch kept when hi not winner", rd_data, 8'h74);
    wr(8'h08); do_ei();
    chk("R8 hi unmasked", {5'b0, irq_code}, 8'h04);
    do_ack();
    chk("R9 ack of hi clears latch", rd_data, 8'h30);

    do_ei();
    chk("R10 enable", rd_data, 8'h38);
    ei_stb = 1; di_stb = 1; tick(); ei_stb = 0; di_stb = 0;
    chk("R10 disable wins", rd_data, 8'h30);
    ei_stb = 1; ack = 1; tick(); ei_stb = 0; ack = 0;
    chk("R10 ack wins", rd_data, 8'h30);

    irq_hi = 1; wr(8'h10);
    chk("R11 clear beats edge", rd_data, 8'h30);
    tick();
    chk("R11 held level no edge", rd_data, 8'h30);
    irq_hi = 0; ser_in = 1; #1;
    chk("R2 serial in bit", rd_data, 8'hB0);
    wr(8'h20);
    chk("R4 bit5 no effect", {7'b0, ser_out}, 8'h01);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule